// File: doc/BRIEF.md
# Sprite Line Evaluator and Pixel Mixer

This block prepares the sprites for one scanline and then blends them into the background while that line is drawn. A pulse on `eval_start` latches the target line. The block then walks a 64-record object memory in ascending order. Each record is four bytes: vertical position at offset 0, tile number at offset 1, attribute byte at offset 2 and horizontal position at offset 3. Up to eight records whose vertical span covers the target line go into an internal line buffer. If a further match is found, the overflow flag is set and the walk ends there. Next, the block reads two pattern bytes for every buffered record through the pattern memory port and keeps them in local registers.

While the line is drawn, the caller presents one dot per cycle: `pix_valid`, `pix_x` and the 4-bit background index. One cycle later the block returns the merged colour index. It also raises the sprite-zero hit flag when buffer slot 0 draws an opaque pixel over a non-zero background. Palette lookup and raster timing belong to the caller.

Top module: `spr_line_unit`

## Requirements
- R1: A record is buffered when line >= Y and line < Y + H, where Y is record byte 0 and H is 16 if `tall_mode` is 1, else 8. Records enter the buffer in ascending table order, and buffer slot k holds the k-th match.
- R2: At most eight records are buffered. A ninth match sets `overflow` and ends the walk, so later records are neither examined nor buffered.
- R3: `overflow` and `zero_hit` stay set across further evaluations and pixels. They clear only on reset or on a `flag_clr` cycle.
- R4: `busy` rises on the cycle after `eval_start` and stays high for exactly 2*B + 1 + 4*C cycles. B is the number of object bytes read (one per record examined plus three per buffered record) and C is the number of buffered records.
- R5: For 8-line sprites, the pattern address is {`small_tbl_hi`, tile[7:0], plane, row[2:0]}. Plane 0 is the low bit plane and plane 1 is the high bit plane.
- R6: For 16-line sprites, the pattern address is {tile[0], tile[7:1], 0, plane, row[2:0]}, and `small_tbl_hi` is ignored.
- R7: The row is line − Y. When attribute bit 7 is set, it becomes H − 1 − (line − Y). Only its low three bits address the pattern.
- R8: A sprite covers dots X to X+7, where X is record byte 3. The pixel takes bit 7 − (x − X) of both planes, or bit (x − X) when attribute bit 6 is set. The value is 2*hi + lo.
- R9: A sprite pixel of 0 is transparent. An opaque pixel that is shown gives `pix_out` = 16 + 4*attr[1:0] + pixel. Otherwise `pix_out` = {0, `bg_index`}.
- R10: The chosen sprite pixel is shown when its attribute bit 5 is clear or `bg_index` is 0. Otherwise the background is shown.
- R11: Where several buffered sprites are opaque, the lowest buffer slot is chosen. A chosen sprite that sits behind the background still hides the higher slots.
- R12: `zero_hit` is set when buffer slot 0 is opaque at a valid dot with `bg_index` non-zero and `spr_en` high.
- R13: With `spr_en` low, `pix_out` equals the background and `zero_hit` is not set.
- R14: `pix_out` is registered and reflects the dot inputs of the previous cycle. It is 0 when `pix_valid` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_start | input | 1 | Start a buffer fill for `eval_line` |
| eval_line | input | 8 | Target line number |
| tall_mode | input | 1 | 1 selects 16-line sprites |
| small_tbl_hi | input | 1 | Pattern table half for 8-line sprites |
| spr_en | input | 1 | Sprite drawing enable |
| flag_clr | input | 1 | Clears `overflow` and `zero_hit` |
| obj_addr | output | 8 | Object memory byte address {record, byte} |
| obj_data | input | 8 | Object memory data, one cycle after address |
| pat_addr | output | 13 | Pattern memory address |
| pat_data | input | 8 | Pattern memory data, one cycle after address |
| pix_valid | input | 1 | Current dot is drawn |
| pix_x | input | 8 | Dot column |
| bg_index | input | 4 | Background colour index for this dot |
| pix_out | output | 5 | Merged colour index |
| zero_hit | output | 1 | Sticky sprite-zero hit flag |
| overflow | output | 1 | Sticky overflow flag |
| busy | output | 1 | Buffer fill or pattern fetch in progress |

## Verification
Buffer-fill results are due 2*B + 1 + 4*C cycles after the start edge. The bench works out B and C from its own walk of the object table. It counts the cycles for which `busy` is high, and only then checks `overflow` and the pixels that depend on the new buffer. Pixel results and the hit flag are due one cycle after the dot is presented. On every clock, the bench compares `pix_out` and `zero_hit` at the falling edge with a reference that was computed from the inputs applied at the previous falling edge.

// File: rtl/spr_line_pkg.sv
package spr_line_pkg;
  typedef struct packed {
    logic [7:0] y;
    logic [7:0] tile;
    logic [7:0] attr;
    logic [7:0] x;
  } obj_rec_t;

  localparam int unsigned REC_BYTES = 4;

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction
endpackage

// File: rtl/spr_scan.sv
module spr_scan
  import spr_line_pkg::*;
#(
  parameter int OBJ_COUNT = 64,
  parameter int SLOTS     = 8,
  localparam int IDXW = $clog2(OBJ_COUNT),
  localparam int SLW  = $clog2(SLOTS),
  localparam int CNTW = $clog2(SLOTS + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [7:0]             line_in,
  input  logic                   tall,
  output logic [IDXW+1:0]        obj_addr,
  input  logic [7:0]             obj_data,
  output obj_rec_t [SLOTS-1:0]   slots,
  output logic [CNTW-1:0]        count,
  output logic [7:0]             line_q,
  output logic                   done_q,
  output logic                   ovf_hit,
  output logic                   busy
);
  typedef enum logic [1:0] {SC_IDLE, SC_Y, SC_COPY} sc_st_t;

  sc_st_t          st;
  logic            phase;
  logic [IDXW-1:0] idx;
  logic [1:0]      bsel;
  logic [8:0]      ydiff;
  logic            in_range, last_idx, full, finish;
  logic [SLW-1:0]  wslot;

  assign obj_addr = {idx, bsel};
  assign ydiff    = {1'b0, line_q} - {1'b0, obj_data};
  assign in_range = !ydiff[8] && (ydiff[7:0] < (tall ? 8'd16 : 8'd8));
  assign last_idx = (idx == IDXW'(OBJ_COUNT - 1));
  assign full     = (count == CNTW'(SLOTS));
  assign wslot    = count[SLW-1:0];
  assign ovf_hit  = (st == SC_Y) && phase && in_range && full;
  assign finish   = ((st == SC_Y) && phase && ((in_range && full) || (!in_range && last_idx)))
                 || ((st == SC_COPY) && phase && (bsel == 2'd3) && last_idx);
  assign busy     = (st != SC_IDLE) || done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SC_IDLE;
      phase  <= 1'b0;
      idx    <= '0;
      bsel   <= '0;
      count  <= '0;
      line_q <= '0;
      slots  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      case (st)
        SC_IDLE: begin
          if (start) begin
            st     <= SC_Y;
            phase  <= 1'b0;
            idx    <= '0;
            bsel   <= '0;
            count  <= '0;
            line_q <= line_in;
          end
        end
        SC_Y: begin
          phase <= !phase;
          if (phase) begin
            if (in_range) begin
              if (full) st <= SC_IDLE;
              else begin
                slots[wslot].y <= obj_data;
                bsel <= 2'd1;
                st   <= SC_COPY;
              end
            end else if (last_idx) st <= SC_IDLE;
            else idx <= idx + 1'b1;
          end
        end
        SC_COPY: begin
          phase <= !phase;
          if (phase) begin
            case (bsel)
              2'd1:    slots[wslot].tile <= obj_data;
              2'd2:    slots[wslot].attr <= obj_data;
              default: slots[wslot].x    <= obj_data;
            endcase
            if (bsel == 2'd3) begin
              count <= count + 1'b1;
              bsel  <= 2'd0;
              if (last_idx) st <= SC_IDLE;
              else begin
                idx <= idx + 1'b1;
                st  <= SC_Y;
              end
            end else bsel <= bsel + 1'b1;
          end
        end
        default: st <= SC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spr_fetch.sv
module spr_fetch
  import spr_line_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int SLW  = $clog2(SLOTS),
  localparam int CNTW = $clog2(SLOTS + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  obj_rec_t [SLOTS-1:0]        slots,
  input  logic [CNTW-1:0]             count,
  input  logic [7:0]                  line_q,
  input  logic                        tall,
  input  logic                        tbl_hi,
  output logic [12:0]                 pat_addr,
  input  logic [7:0]                  pat_data,
  output logic [SLOTS-1:0][7:0]       pat_lo,
  output logic [SLOTS-1:0][7:0]       pat_hi,
  output logic                        busy
);
  logic           active, phase, plane;
  logic [SLW-1:0] fs;
  obj_rec_t       sel;
  logic [2:0]     ofs, row;
  logic [7:0]     store;

  assign sel   = slots[fs];
  assign ofs   = line_q[2:0] - sel.y[2:0];
  assign row   = sel.attr[7] ? ~ofs : ofs;
  assign store = sel.attr[6] ? rev8(pat_data) : pat_data;
  assign busy  = active;

  always_comb begin
    if (tall) pat_addr = {sel.tile[0], sel.tile[7:1], 1'b0, plane, row};
    else      pat_addr = {tbl_hi, sel.tile, plane, row};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      phase  <= 1'b0;
      plane  <= 1'b0;
      fs     <= '0;
      pat_lo <= '0;
      pat_hi <= '0;
    end else if (!active) begin
      if (start && (count != '0)) begin
        active <= 1'b1;
        phase  <= 1'b0;
        plane  <= 1'b0;
        fs     <= '0;
      end
    end else begin
      phase <= !phase;
      if (phase) begin
        if (plane) pat_hi[fs] <= store;
        else       pat_lo[fs] <= store;
        plane <= !plane;
        if (plane) begin
          if ((CNTW'(fs) + 1'b1) == count) active <= 1'b0;
          else fs <= fs + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spr_mix.sv
module spr_mix
  import spr_line_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int SLW  = $clog2(SLOTS),
  localparam int CNTW = $clog2(SLOTS + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  obj_rec_t [SLOTS-1:0]   slots,
  input  logic [SLOTS-1:0][7:0]  pat_lo,
  input  logic [SLOTS-1:0][7:0]  pat_hi,
  input  logic [CNTW-1:0]        count,
  input  logic                   pix_valid,
  input  logic [7:0]             pix_x,
  input  logic [3:0]             bg_index,
  input  logic                   spr_en,
  output logic [4:0]             pix_out,
  output logic                   hit_now
);
  logic [SLOTS-1:0]      opaque;
  logic [SLOTS-1:0][1:0] pxv;
  logic [SLW-1:0]        win;
  logic                  shown;
  logic [4:0]            nxt;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [8:0] dx;
    logic [2:0] bi;
    logic       covered;
    assign dx       = {1'b0, pix_x} - {1'b0, slots[s].x};
    assign covered  = !dx[8] && (dx[7:3] == 5'd0) && (CNTW'(s) < count);
    assign bi       = 3'd7 - dx[2:0];
    assign pxv[s]   = {pat_hi[s][bi], pat_lo[s][bi]};
    assign opaque[s] = covered && (pxv[s] != 2'd0);
  end

  always_comb begin
    win = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (opaque[s]) win = SLW'(s);
    end
  end

  assign shown   = spr_en && (|opaque) && (!slots[win].attr[5] || (bg_index == 4'd0));
  assign hit_now = pix_valid && spr_en && opaque[0] && (bg_index != 4'd0);

  always_comb begin
    if (!pix_valid) nxt = 5'd0;
    else if (shown) nxt = {1'b1, slots[win].attr[1:0], pxv[win]};
    else nxt = {1'b0, bg_index};
  end

  always_ff @(posedge clk) begin
    if (rst) pix_out <= 5'd0;
    else     pix_out <= nxt;
  end
endmodule

// File: rtl/spr_line_unit.sv
module spr_line_unit
  import spr_line_pkg::*;
#(
  parameter int OBJ_COUNT = 64,
  parameter int SLOTS     = 8,
  localparam int OBJ_AW   = $clog2(OBJ_COUNT * REC_BYTES),
  localparam int CNTW     = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eval_start,
  input  logic [7:0]        eval_line,
  input  logic              tall_mode,
  input  logic              small_tbl_hi,
  input  logic              spr_en,
  input  logic              flag_clr,
  output logic [OBJ_AW-1:0] obj_addr,
  input  logic [7:0]        obj_data,
  output logic [12:0]       pat_addr,
  input  logic [7:0]        pat_data,
  input  logic              pix_valid,
  input  logic [7:0]        pix_x,
  input  logic [3:0]        bg_index,
  output logic [4:0]        pix_out,
  output logic              zero_hit,
  output logic              overflow,
  output logic              busy
);
  obj_rec_t [SLOTS-1:0]  slots;
  logic [SLOTS-1:0][7:0] pat_lo, pat_hi;
  logic [CNTW-1:0]       count;
  logic [7:0]            line_q;
  logic                  scan_done, ovf_hit, scan_busy, fetch_busy, hit_now;

  spr_scan #(.OBJ_COUNT(OBJ_COUNT), .SLOTS(SLOTS)) u_scan (
    .clk(clk), .rst(rst), .start(eval_start), .line_in(eval_line), .tall(tall_mode),
    .obj_addr(obj_addr), .obj_data(obj_data), .slots(slots), .count(count),
    .line_q(line_q), .done_q(scan_done), .ovf_hit(ovf_hit), .busy(scan_busy)
  );

  spr_fetch #(.SLOTS(SLOTS)) u_fetch (
    .clk(clk), .rst(rst), .start(scan_done), .slots(slots), .count(count),
    .line_q(line_q), .tall(tall_mode), .tbl_hi(small_tbl_hi), .pat_addr(pat_addr),
    .pat_data(pat_data), .pat_lo(pat_lo), .pat_hi(pat_hi), .busy(fetch_busy)
  );

  spr_mix #(.SLOTS(SLOTS)) u_mix (
    .clk(clk), .rst(rst), .slots(slots), .pat_lo(pat_lo), .pat_hi(pat_hi),
    .count(count), .pix_valid(pix_valid), .pix_x(pix_x), .bg_index(bg_index),
    .spr_en(spr_en), .pix_out(pix_out), .hit_now(hit_now)
  );

  assign busy = scan_busy || fetch_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      overflow <= 1'b0;
      zero_hit <= 1'b0;
    end else begin
      if (ovf_hit)       overflow <= 1'b1;
      else if (flag_clr) overflow <= 1'b0;
      if (hit_now)       zero_hit <= 1'b1;
      else if (flag_clr) zero_hit <= 1'b0;
    end
  end
endmodule

// File: rtl/spr_line_unit_chk.sv
module spr_line_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       flag_clr,
  input logic       pix_valid,
  input logic       spr_en,
  input logic [4:0] pix_out,
  input logic       zero_hit,
  input logic       overflow,
  input logic       busy
);
  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(overflow) |-> $past(flag_clr));
  assert_hit_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(zero_hit) |-> $past(flag_clr));
  assert_idle_dot_R14: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> (pix_out == 5'd0));
  assert_off_is_bg_R13: assert property (@(posedge clk) disable iff (rst)
    !spr_en |=> !pix_out[4]);
  assert_hit_cause_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(zero_hit) |-> $past(pix_valid && spr_en));
  assert_ovf_during_scan_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(busy));
endmodule

bind spr_line_unit spr_line_unit_chk i_chk (.*);

// File: tb/test_spr_line_unit.sv
module test_spr_line_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       eval_start = 1'b0;
  logic [7:0] eval_line = 8'd0;
  logic       tall_mode = 1'b0;
  logic       small_tbl_hi = 1'b0;
  logic       spr_en = 1'b0;
  logic       flag_clr = 1'b0;
  logic [7:0] obj_addr;
  logic [7:0] obj_data;
  logic [12:0] pat_addr;
  logic [7:0] pat_data;
  logic       pix_valid = 1'b0;
  logic [7:0] pix_x = 8'd0;
  logic [3:0] bg_index = 4'd0;
  logic [4:0] pix_out;
  logic       zero_hit, overflow, busy;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] obj_mem [0:255];

  always #10 clk = !clk;

  spr_line_unit i_spr_line_unit (.*);

  function automatic logic [7:0] pat_fn(input logic [12:0] a);
    logic [15:0] h;
    if (a[11:4] == 8'd0) return 8'h00;
    if (a[11:4] == 8'd1) return a[3] ? 8'h00 : 8'hFF;
    if (a[11:4] == 8'd2) return a[3] ? 8'hFF : 8'h00;
    h = ({3'b000, a} * 16'd40503) ^ ({3'b000, a} << 7);
    return h[15:8] ^ h[7:0];
  endfunction

  always @(posedge clk) begin
    obj_data <= obj_mem[obj_addr];
    pat_data <= pat_fn(pat_addr);
  end

  // reference model state
  int m_cnt;
  int m_y[8], m_t[8], m_a[8], m_x[8];
  bit m_ovf, m_hit;
  int m_line;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_oam();
    for (int i = 0; i < 256; i++) obj_mem[i] = ((i % 4) == 0) ? 8'hF0 : 8'h00;
  endtask

  task automatic put(input int i, input int y, input int t, input int a, input int x);
    obj_mem[4*i]   = 8'(y);
    obj_mem[4*i+1] = 8'(t);
    obj_mem[4*i+2] = 8'(a);
    obj_mem[4*i+3] = 8'(x);
  endtask

  // run one evaluation; checks busy length (R4) and overflow (R2/R3)
  task automatic evaluate(input int line, input bit tall, input string tag);
    int h, b, n;
    h = tall ? 16 : 8;
    b = 0;
    m_cnt = 0;
    m_line = line;
    for (int i = 0; i < 64; i++) begin
      int y;
      y = obj_mem[4*i];
      b++;
      if (line >= y && line < y + h) begin
        if (m_cnt == 8) begin m_ovf = 1; break; end
        m_y[m_cnt] = y; m_t[m_cnt] = obj_mem[4*i+1];
        m_a[m_cnt] = obj_mem[4*i+2]; m_x[m_cnt] = obj_mem[4*i+3];
        m_cnt++;
        b += 3;
      end
    end
    @(negedge clk);
    eval_line = 8'(line);
    tall_mode = tall;
    eval_start = 1'b1;
    @(negedge clk);
    eval_start = 1'b0;
    n = 0;
    while (busy && n < 5000) begin
      n++;
      @(negedge clk);
    end
    check(n == 2*b + 1 + 4*m_cnt, {"R4 busy length ", tag}, n, 2*b + 1 + 4*m_cnt);
    check(overflow == m_ovf, {"R2 R3 overflow ", tag}, int'(overflow), int'(m_ovf));
  endtask

  function automatic void ref_pix(input int x, input int bg, input bit valid, input bit en,
                                  output int out, output bit hit);
    bit found;
    int fp, fa;
    found = 0; fp = 0; fa = 0; hit = 0;
    for (int s = 0; s < m_cnt; s++) begin
      if (x >= m_x[s] && x < m_x[s] + 8) begin
        int h, oy, base, tile, addr, lo, hi, sh, p;
        h = tall_mode ? 16 : 8;
        oy = m_line - m_y[s];
        if (m_a[s] & 8'h80) oy = h - 1 - oy;
        if (tall_mode) begin
          base = (m_t[s] & 1) ? 4096 : 0;
          tile = m_t[s] & 8'hFE;
        end else begin
          base = small_tbl_hi ? 4096 : 0;
          tile = m_t[s];
        end
        addr = base + tile * 16 + (oy & 7);
        lo = pat_fn(13'(addr));
        hi = pat_fn(13'(addr + 8));
        sh = (m_a[s] & 8'h40) ? (x - m_x[s]) : (7 - (x - m_x[s]));
        p = ((hi >> sh) & 1) * 2 + ((lo >> sh) & 1);
        if (p != 0) begin
          if (s == 0 && bg != 0 && valid && en) hit = 1;
          if (!found) begin found = 1; fp = p; fa = m_a[s]; end
        end
      end
    end
    if (!valid) out = 0;
    else if (en && found && (((fa & 8'h20) == 0) || bg == 0)) out = 16 + (fa & 3) * 4 + fp;
    else out = bg;
  endfunction

  // drive a full line of dots; compare output and hit flag every clock
  task automatic sweep(input bit en, input int seed, input string tag);
    int exp_out;
    bit exp_hit;
    exp_out = 0;
    spr_en = en;
    for (int k = -3; k < 260; k++) begin
      @(negedge clk);
      if (k > -3) begin
        check(int'(pix_out) == exp_out, {"pix_out ", tag}, int'(pix_out), exp_out);
        check(zero_hit == m_hit, {"R12 R3 zero_hit ", tag}, int'(zero_hit), int'(m_hit));
      end
      pix_valid = (k >= 0 && k < 256);
      pix_x = 8'(k);
      bg_index = 4'((k * 7 + seed) % 16);
      ref_pix(int'(pix_x), int'(bg_index), pix_valid, en, exp_out, exp_hit);
      if (exp_hit) m_hit = 1;
    end
    @(negedge clk);
    check(int'(pix_out) == exp_out, {"R14 final ", tag}, int'(pix_out), exp_out);
    pix_valid = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    m_ovf = 0;
    m_hit = 0;
    check(overflow == 1'b0, "R3 overflow cleared", int'(overflow), 0);
    check(zero_hit == 1'b0, "R3 zero_hit cleared", int'(zero_hit), 0);
  endtask

  initial begin
    m_ovf = 0; m_hit = 0; m_cnt = 0; m_line = 0;
    clear_oam();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pix_out == 5'd0, "R14 reset pix_out", int'(pix_out), 0);
    check(overflow == 1'b0, "R3 reset overflow", int'(overflow), 0);
    check(zero_hit == 1'b0, "R3 reset zero_hit", int'(zero_hit), 0);
    check(busy == 1'b0, "R4 reset busy", int'(busy), 0);

    // empty line: every record examined, nothing buffered
    evaluate(50, 0, "empty");
    sweep(1, 3, "R9 empty line shows background");

    // mixed 8-line set: range edges, order, flips, priority, hit
    put(0, 51, 1, 8'h00, 0);     // starts below line: out (R1)
    put(3, 45, 1, 8'h01, 20);    // slot 0, pixel 1 palette 1
    put(5, 50, 2, 8'h22, 24);    // behind background, overlaps slot 0 (R10 R11)
    put(9, 43, 7, 8'h40, 100);   // last covered row, hflip (R8)
    put(10, 42, 7, 8'h00, 100);  // one past span: out (R1)
    put(20, 47, 9, 8'h83, 200);  // vflip (R7)
    put(21, 49, 2, 8'h00, 40);   // front sprite
    evaluate(50, 0, "eight-line set");
    sweep(1, 3, "R1 R5 R8 R9 R10 R11");
    sweep(1, 0, "R10 R11 alt background");
    small_tbl_hi = 1'b1;
    evaluate(50, 0, "upper table");
    sweep(1, 5, "R5 upper table");
    small_tbl_hi = 1'b0;
    check(zero_hit == 1'b1, "R12 hit reached", int'(zero_hit), 1);
    clear_flags();

    // overflow: ten matches, only the first eight buffered
    clear_oam();
    for (int i = 0; i < 8; i++) put(2 + i * 3, 60, 3 + i, i, i * 24);
    put(40, 58, 1, 8'h03, 210);  // ninth: must not be drawn
    put(41, 59, 1, 8'h03, 230);  // tenth: never examined
    evaluate(62, 0, "ninth match");
    check(overflow == 1'b1, "R2 overflow set", int'(overflow), 1);
    sweep(1, 1, "R2 cap of eight");

    // overflow stays through a later evaluation without overflow
    clear_oam();
    put(1, 60, 1, 0, 10);
    evaluate(62, 0, "sticky");
    check(overflow == 1'b1, "R3 overflow sticky", int'(overflow), 1);
    clear_flags();

    // 16-line set, table select ignored
    clear_oam();
    small_tbl_hi = 1'b1;
    put(2, 30, 8'h35, 8'h80, 60);
    put(4, 38, 8'h12, 8'h41, 64);
    put(6, 25, 8'h77, 8'h02, 150);
    put(7, 24, 8'h55, 8'h00, 170); // one past 16-line span: out
    put(8, 33, 8'h1B, 8'hC3, 180);
    evaluate(40, 1, "sixteen-line set");
    sweep(1, 6, "R6 R7 R8 sixteen-line");

    // sprites disabled
    sweep(0, 6, "R13 disabled");
    check(zero_hit == m_hit, "R13 no hit while disabled", int'(zero_hit), int'(m_hit));

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule